// File: doc/BRIEF.md
# Display line timing and status generator

This block paces a small LCD video pipeline. A dot counter divides every line into a draw phase followed by a horizontal-blank phase. A line counter steps forward at the start of each draw phase and wraps at the end of the frame. A 16-bit status word holds the live blanking and line-compare flags, three interrupt enables and a 9-bit compare line. The block turns the timing events into single-cycle interrupt pulses.

During horizontal blank the block also tells two renderers what to draw. The 2D engine receives a strobe and the current line number on each visible line. A 3D engine that works ahead of the display receives a strobe for the line a fixed number of lines in advance. That target line wraps into the next frame when the current line is near the bottom.

The CPU writes the status word through a write-enable and data port. Such a write never changes the three flag bits, which belong to the hardware. After reset the block sits on line 0 in the draw phase with all flags clear. A line-compare check takes place only when a line is entered, so line 0 of the first frame after reset is never compared.

Top module: `lcd_line_timer`

## Requirements
- R1: Each line has DRAW_DOTS clocks of draw phase, then LINE_DOTS minus DRAW_DOTS clocks of hblank. Status bit 1 (hblank) is set on the clock that enters hblank and cleared on the clock that enters the draw phase.
- R2: The line counter on `line_count` increments on entry to the draw phase and goes from TOTAL_LINES-1 back to 0. It holds its value at all other times.
- R3: On each entry to the draw phase, status bit 2 (line match) takes the value "new line equals compare line". The compare line is {bit 7, bits 15:8} of the status word. When bit 5 is set and the lines match, `irq_match` pulses in the same cycle that the flag is updated.
- R4: Status bit 0 (vblank) is set when the line counter becomes VIS_LINES and cleared when it becomes TOTAL_LINES-1. `irq_vblank` pulses at the set when status bit 3 is 1.
- R5: `irq_hblank` pulses in the cycle the hblank flag rises, when status bit 4 is 1.
- R6: A write with `stat_we` stores `stat_wdata[15:3]` into status bits 15:3 and leaves bits 2:0 as the hardware holds them.
- R7: On hblank entry of a line below VIS_LINES, `draw2d_stb` pulses for one cycle with `draw2d_line` equal to that line. No pulse occurs on the other lines.
- R8: On hblank entry, `draw3d_stb` pulses with line+AHEAD when that value is below VIS_LINES. It pulses with line+AHEAD-TOTAL_LINES when line is at least TOTAL_LINES-AHEAD. Otherwise it does not pulse.
- R9: After reset the status word, the line counter, all pulses and both strobes are 0.
- R10: Every interrupt and strobe output is a single-cycle pulse, and the hblank interrupt never coincides with a draw-entry interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 16 | Status write data |
| stat_rdata | output | 16 | Current status word |
| line_count | output | 9 | Current line counter |
| irq_hblank | output | 1 | Hblank interrupt pulse |
| irq_vblank | output | 1 | Vblank interrupt pulse |
| irq_match | output | 1 | Line-match interrupt pulse |
| draw2d_stb | output | 1 | 2D render strobe |
| draw2d_line | output | 9 | Line for the 2D render strobe |
| draw3d_stb | output | 1 | 3D render strobe |
| draw3d_line | output | 9 | Look-ahead line for the 3D render strobe |

## Verification
The bench runs the block with a shrunken geometry so that whole frames fit in a few hundred cycles. It compares every output on every cycle against a dot-and-line model. The first run uses a compare line inside the visible area with all enables on, which separates the match, vblank and hblank pulses. A second run sets compare bit 8, which shows whether that bit takes part in the compare. A third run clears every enable, so the flags must change while the pulses stay low. A write of all-ones in the low bits during hblank shows whether the hardware flags survive a CPU write. The sweep passes through the lines just below the visible limit and the last lines of the frame, which exercises both the non-wrapping and the wrapping 3D target and the gap between them.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    localparam int LINE_W = 9;
    typedef logic [LINE_W-1:0] line_t;

    // Writable part of the status word, bits 15:3
    typedef struct packed {
        logic [7:0] cmp_lo;    // bits 15:8
        logic       cmp_hi;    // bit 7
        logic       spare;     // bit 6
        logic       en_match;  // bit 5
        logic       en_hblank; // bit 4
        logic       en_vblank; // bit 3
    } stat_ctrl_t;

    // Hardware-owned part, bits 2:0
    typedef struct packed {
        logic match;   // bit 2
        logic hblank;  // bit 1
        logic vblank;  // bit 0
    } stat_flags_t;

    function automatic line_t line_step(line_t cur, int total);
        return (int'(cur) == total - 1) ? '0 : line_t'(cur + 1'b1);
    endfunction

    function automatic line_t cmp_line(stat_ctrl_t c);
        return {c.cmp_hi, c.cmp_lo};
    endfunction

endpackage

// File: rtl/lcd_hphase.sv
module lcd_hphase #(
    parameter int DRAW_DOTS = 256,
    parameter int LINE_DOTS = 355
) (
    input  logic clk,
    input  logic rst,
    output logic hb_enter,
    output logic draw_enter
);
    localparam int DW = $clog2(LINE_DOTS);

    logic [DW-1:0] dot_q;

    always_comb begin
        hb_enter   = (dot_q == DW'(DRAW_DOTS - 1));
        draw_enter = (dot_q == DW'(LINE_DOTS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst)             dot_q <= '0;
        else if (draw_enter) dot_q <= '0;
        else                 dot_q <= dot_q + 1'b1;
    end

    assert_dot_range_R1: assert property (@(posedge clk) disable iff (rst)
        int'(dot_q) < LINE_DOTS);
    assert_entries_apart_R1: assert property (@(posedge clk) disable iff (rst)
        !(hb_enter && draw_enter));
endmodule

// File: rtl/lcd_vcount.sv
module lcd_vcount
    import lcd_timing_pkg::*;
#(
    parameter int TOTAL_LINES = 263
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  draw_enter,
    output line_t line_q,
    output line_t line_nx
);
    always_comb line_nx = line_step(line_q, TOTAL_LINES);

    always_ff @(posedge clk) begin
        if (rst)             line_q <= '0;
        else if (draw_enter) line_q <= line_nx;
    end

    assert_line_range_R2: assert property (@(posedge clk) disable iff (rst)
        int'(line_q) < TOTAL_LINES);
    assert_line_moves_on_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (line_q != $past(line_q)) |-> $past(draw_enter));
endmodule

// File: rtl/lcd_status.sv
module lcd_status
    import lcd_timing_pkg::*;
#(
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hb_enter,
    input  logic        draw_enter,
    input  line_t       line_nx,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq_hb,
    output logic        irq_vb,
    output logic        irq_mt
);
    stat_ctrl_t  ctrl_q;
    stat_flags_t flags_q;
    logic        hit_cmp, hit_vis, hit_end;

    always_comb begin
        hit_cmp = (line_nx == cmp_line(ctrl_q));
        hit_vis = (int'(line_nx) == VIS_LINES);
        hit_end = (int'(line_nx) == TOTAL_LINES - 1);
        rdata   = {ctrl_q, flags_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            irq_hb  <= 1'b0;
            irq_vb  <= 1'b0;
            irq_mt  <= 1'b0;
        end else begin
            irq_hb <= hb_enter && ctrl_q.en_hblank;
            irq_vb <= draw_enter && hit_vis && ctrl_q.en_vblank;
            irq_mt <= draw_enter && hit_cmp && ctrl_q.en_match;
            if (hb_enter) flags_q.hblank <= 1'b1;
            if (draw_enter) begin
                flags_q.hblank <= 1'b0;
                flags_q.match  <= hit_cmp;
                if (hit_vis)      flags_q.vblank <= 1'b1;
                else if (hit_end) flags_q.vblank <= 1'b0;
            end
            if (we) ctrl_q <= stat_ctrl_t'(wdata[15:3]);
        end
    end

    assert_flags_kept_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        (we && !hb_enter && !draw_enter) |=> $stable(flags_q));
    assert_vblank_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
        irq_vb |=> !irq_vb);
    assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(irq_hb && (irq_vb || irq_mt)));
    assert_match_irq_flag_R3: assert property (@(posedge clk) disable iff (rst)
        irq_mt |-> flags_q.match);
endmodule

// File: rtl/lcd_render_strobe.sv
module lcd_render_strobe
    import lcd_timing_pkg::*;
#(
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    parameter int AHEAD       = 48
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hb_enter,
    input  line_t line_q,
    output logic  s2d,
    output line_t l2d,
    output logic  s3d,
    output line_t l3d
);
    logic [LINE_W:0] ahead;
    logic            go_near, go_wrap;

    always_comb begin
        ahead   = {1'b0, line_q} + (LINE_W+1)'(AHEAD);
        go_near = int'(ahead) < VIS_LINES;
        go_wrap = int'(line_q) >= TOTAL_LINES - AHEAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2d <= 1'b0;
            l2d <= '0;
            s3d <= 1'b0;
            l3d <= '0;
        end else begin
            s2d <= hb_enter && (int'(line_q) < VIS_LINES);
            s3d <= hb_enter && (go_near || go_wrap);
            if (hb_enter) begin
                l2d <= line_q;
                if (go_near)      l3d <= line_t'(ahead);
                else if (go_wrap) l3d <= line_t'(ahead - (LINE_W+1)'(TOTAL_LINES));
            end
        end
    end

    assert_3d_in_view_R8: assert property (@(posedge clk) disable iff (rst)
        s3d |-> int'(l3d) < VIS_LINES);
    assert_2d_single_R10: assert property (@(posedge clk) disable iff (rst)
        s2d |=> !s2d);
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
    import lcd_timing_pkg::*;
#(
    parameter int DRAW_DOTS   = 256,
    parameter int LINE_DOTS   = 355,
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    parameter int AHEAD       = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stat_we,
    input  logic [15:0] stat_wdata,
    output logic [15:0] stat_rdata,
    output logic [8:0]  line_count,
    output logic        irq_hblank,
    output logic        irq_vblank,
    output logic        irq_match,
    output logic        draw2d_stb,
    output logic [8:0]  draw2d_line,
    output logic        draw3d_stb,
    output logic [8:0]  draw3d_line
);
    logic  hb_enter, draw_enter;
    line_t line_q, line_nx;

    lcd_hphase #(.DRAW_DOTS(DRAW_DOTS), .LINE_DOTS(LINE_DOTS)) u_hphase (
        .clk(clk), .rst(rst), .hb_enter(hb_enter), .draw_enter(draw_enter));

    lcd_vcount #(.TOTAL_LINES(TOTAL_LINES)) u_vcount (
        .clk(clk), .rst(rst), .draw_enter(draw_enter),
        .line_q(line_q), .line_nx(line_nx));

    lcd_status #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)) u_status (
        .clk(clk), .rst(rst), .hb_enter(hb_enter), .draw_enter(draw_enter),
        .line_nx(line_nx), .we(stat_we), .wdata(stat_wdata), .rdata(stat_rdata),
        .irq_hb(irq_hblank), .irq_vb(irq_vblank), .irq_mt(irq_match));

    lcd_render_strobe #(.VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES),
                        .AHEAD(AHEAD)) u_strobe (
        .clk(clk), .rst(rst), .hb_enter(hb_enter), .line_q(line_q),
        .s2d(draw2d_stb), .l2d(draw2d_line), .s3d(draw3d_stb), .l3d(draw3d_line));

    assign line_count = line_q;
endmodule

// File: tb/lcd_line_timer_tb_top.sv
module lcd_line_timer_tb_top;
    localparam int DRAW  = 6;
    localparam int LINE  = 10;
    localparam int VIS   = 8;
    localparam int TOTAL = 12;
    localparam int AH    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stat_we = 1'b0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;
    logic [8:0]  line_count, draw2d_line, draw3d_line;
    logic        irq_hblank, irq_vblank, irq_match, draw2d_stb, draw3d_stb;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    lcd_line_timer #(.DRAW_DOTS(DRAW), .LINE_DOTS(LINE), .VIS_LINES(VIS),
                     .TOTAL_LINES(TOTAL), .AHEAD(AH)) dut_i (
        .clk(clk), .rst(rst), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .line_count(line_count),
        .irq_hblank(irq_hblank), .irq_vblank(irq_vblank), .irq_match(irq_match),
        .draw2d_stb(draw2d_stb), .draw2d_line(draw2d_line),
        .draw3d_stb(draw3d_stb), .draw3d_line(draw3d_line));

    // Reference model built from the requirements
    int          m_dot, m_line;
    logic [15:0] m_ctrl;
    logic        m_vb, m_hb, m_mt, e_ih, e_iv, e_im, e_s2, e_s3;
    int          e_l2, e_l3;

    always @(posedge clk) begin
        if (rst) begin
            m_dot = 0; m_line = 0; m_ctrl = '0;
            m_vb = 0; m_hb = 0; m_mt = 0;
            e_ih = 0; e_iv = 0; e_im = 0; e_s2 = 0; e_s3 = 0;
            e_l2 = 0; e_l3 = 0;
        end else begin
            automatic bit hbe = (m_dot == DRAW - 1);
            automatic bit dre = (m_dot == LINE - 1);
            automatic int cmp = {m_ctrl[7], m_ctrl[15:8]};
            e_ih = hbe && m_ctrl[4];
            e_iv = 0; e_im = 0;
            e_s2 = hbe && (m_line < VIS);
            e_s3 = 0;
            if (hbe) begin
                m_hb = 1;
                e_l2 = m_line;
                if (m_line + AH < VIS) begin e_s3 = 1; e_l3 = m_line + AH; end
                else if (m_line >= TOTAL - AH) begin e_s3 = 1; e_l3 = m_line + AH - TOTAL; end
            end
            if (dre) begin
                m_dot  = 0;
                m_line = (m_line == TOTAL - 1) ? 0 : m_line + 1;
                m_hb   = 0;
                m_mt   = (m_line == cmp);
                e_im   = m_mt && m_ctrl[5];
                if (m_line == VIS) begin m_vb = 1; e_iv = m_ctrl[3]; end
                else if (m_line == TOTAL - 1) m_vb = 0;
            end else begin
                m_dot = m_dot + 1;
            end
            if (stat_we) m_ctrl = {stat_wdata[15:3], 3'b000};
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        chk(stat_rdata[0] == m_vb, "R4 vblank flag", stat_rdata[0], m_vb);
        chk(stat_rdata[1] == m_hb, "R1 hblank flag", stat_rdata[1], m_hb);
        chk(stat_rdata[2] == m_mt, "R3 match flag", stat_rdata[2], m_mt);
        chk(stat_rdata[15:3] == m_ctrl[15:3], "R6 control bits", stat_rdata, m_ctrl);
        chk(int'(line_count) == m_line, "R2 line counter", line_count, m_line);
        chk(irq_match == e_im, "R3 match irq", irq_match, e_im);
        chk(irq_vblank == e_iv, "R4 vblank irq", irq_vblank, e_iv);
        chk(irq_hblank == e_ih, "R5 hblank irq", irq_hblank, e_ih);
        chk(draw2d_stb == e_s2, "R7 2D strobe", draw2d_stb, e_s2);
        if (e_s2) chk(int'(draw2d_line) == e_l2, "R7 2D line", draw2d_line, e_l2);
        chk(draw3d_stb == e_s3, "R8 3D strobe", draw3d_stb, e_s3);
        if (e_s3) chk(int'(draw3d_line) == e_l3, "R8 3D line", draw3d_line, e_l3);
    endtask

    // Run n cycles; write wval in the cycle whose index is wr_at (-1: none)
    task automatic run(input int n, input int wr_at, input logic [15:0] wval);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            stat_we    = (i == wr_at);
            stat_wdata = wval;
        end
        @(negedge clk);
        stat_we = 1'b0;
        check_all();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(stat_rdata == 16'h0, "R9 status after reset", stat_rdata, 0);
        chk(line_count == 9'd0, "R9 line after reset", line_count, 0);
        chk({irq_hblank, irq_vblank, irq_match, draw2d_stb, draw3d_stb} == 5'b0,
            "R9 pulses after reset", 0, 0);
    endtask

    // R3 R4 R5: compare line 5, all enables on, two full frames
    task automatic t_all_enabled();
        run(2 * LINE * TOTAL + 5, 0, 16'h0538);
    endtask

    // R3: compare bit 8 set (0x104) must never match line 4
    task automatic t_cmp_high_bit();
        run(LINE * TOTAL + 3, 0, 16'h04B8);
    endtask

    // R6: low bits written as ones during hblank, flags must stay hardware-owned
    task automatic t_write_in_hblank();
        while (m_dot != DRAW + 1) begin
            @(negedge clk);
            check_all();
        end
        run(LINE * 2, 0, 16'h0007);
    endtask

    // R3 R4 R5: enables off with compare line 3, flags move and pulses stay low
    task automatic t_irqs_off();
        run(LINE * TOTAL + 7, 0, 16'h0300);
    endtask

    initial begin
        t_reset();
        t_all_enabled();
        t_cmp_high_bit();
        t_write_in_hblank();
        t_irqs_off();
        t_reset();
        run(LINE * 3, -1, 16'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule